// File: doc/BRIEF.md
# Dual-Channel Serial Converter Register Front End

This block is the digital side of a two-channel 12-bit voltage converter. A host clocks a 16-bit word in over a three-wire serial port: data, serial clock and an active-low select. The upper nibble of the word is an address field and the lower twelve bits are a converter code. Pulsing one of two load strobes copies the code into a channel register. The channel is chosen either by which strobe was pulsed or, when the word asks for it, by the address field. The two 12-bit register values are the block's outputs and drive the analog converters.

The last stage of the shift register is brought out on a serial output, so several devices can share one select line in a chain. A clear input forces both channels to a known code. A separate level input chooses that code: zero scale or midscale. All serial-port pins, strobes and levels are asynchronous to the system clock. They pass through a synchronizer, and their edges are found in the system clock domain.

The load path is a three-state machine:
- **IDLE** waits. A rising strobe edge moves it to **COMMIT** and latches the destination and code (transition *strobe*). An active clear moves it to **CLEAR** (transition *clear-in*).
- **COMMIT** writes the latched code into the chosen register or registers. It then returns to IDLE (transition *done*), or goes to CLEAR if clear became active (transition *clear-in*). A clear that is active while in COMMIT cancels the write.
- **CLEAR** fills both registers with the selected code on every cycle. It returns to IDLE when clear drops (transition *clear-out*).

Top module: `dac_serial_front`

## Requirements
- R1: After system reset, both channel outputs read 12'h000 and the serial output reads 0.
- R2: A frame is 16 bits, sent most significant bit first. Bits [11:0] are the code and bits [15:12] the address. Bits 14 and 13 have no effect. One bit is captured on each rising serial clock edge while select is low.
- R3: While select is high, serial clock edges change neither the shift register nor the serial output.
- R4: The serial output takes bit 15 of the shift register on each falling serial clock edge while selected. The first bit of a frame therefore leaves the serial output during the next 16-bit frame, one bit per falling edge.
- R5: When address bit 15 is 0, a rising edge on strobe A loads the code into channel A only, and a rising edge on strobe B loads it into channel B only. Both strobes together load both channels.
- R6: When address bit 15 is 1, a rising edge on either strobe loads only the channel named by bit 12 (0 = A, 1 = B). The other channel is unchanged.
- R7: While clear is active, both channels become 12'h000 if the midscale input is low, and 12'h800 if it is high.
- R8: Clear has priority. A strobe edge in the same cycle as an active clear, or during clear, is ignored. So is a strobe held high across the end of clear.
- R9: A strobe loads once per pulse, on its rising edge. Holding it high while a new word is shifted in does not load the new word.
- R10: Every code from 12'h000 to full scale 12'hFFF reaches the channel output unchanged.
- R11: Serial capture and serial output updates happen on the third system clock edge after the pin change is first sampled. Channel loads and clears take effect on the fourth.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low system reset |
| sclk_i | input | 1 | Serial clock, asynchronous |
| sdi_i | input | 1 | Serial data in |
| cs_n_i | input | 1 | Active-low select for the serial port |
| load_a_i | input | 1 | Load strobe for channel A, rising edge acts |
| load_b_i | input | 1 | Load strobe for channel B, rising edge acts |
| clear_i | input | 1 | Clear, active high, forces both channels |
| mid_i | input | 1 | Clear target: 0 = zero scale, 1 = midscale |
| sdo_o | output | 1 | Serial data out for chaining |
| chan_a_o | output | 12 | Channel A code |
| chan_b_o | output | 12 | Channel B code |

## Verification
The bench targets the points where the load machine and the clear path meet:
- A strobe edge in the same cycle as clear, inside clear, and held high past the end of clear must not load. A design that samples strobe level rather than edge would load a stale word when clear drops.
- A long strobe pulse spans a second serial frame, to catch a design that reloads while the strobe stays high.
- Internally decoded words are loaded with the opposite-channel strobe, to expose a decoder that follows the strobe instead of bit 12.
- The chained serial output is checked bit by bit during a second frame, which exposes an off-by-one in the output stage.
- Clocking with select high exposes a shifter that ignores select.

// File: rtl/dacfe_pkg.sv
package dacfe_pkg;
    localparam int FRAME_W = 16;
    localparam int CODE_W  = 12;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_COMMIT = 2'd1,
        ST_CLEAR  = 2'd2
    } ld_state_e;

    typedef struct packed {
        logic to_a;
        logic to_b;
    } dest_t;
endpackage

// File: rtl/bit_sync.sv
module bit_sync #(
    parameter int N      = 1,
    parameter int STAGES = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] d_i,
    output logic [N-1:0] q_o
);
    logic [STAGES-1:0][N-1:0] stg_q;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= d_i;
            end
        end else begin : g_chain
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) stg_q <= '0;
                else        stg_q <= {stg_q[STAGES-2:0], d_i};
            end
        end
    endgenerate

    assign q_o = stg_q[STAGES-1];
endmodule

// File: rtl/frame_shifter.sv
module frame_shifter #(
    parameter int FRAME_W = 16,
    parameter int CODE_W  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sel_i,
    input  logic              step_rise_i,
    input  logic              step_fall_i,
    input  logic              bit_i,
    output logic [CODE_W-1:0] data_o,
    output logic              dec_en_o,
    output logic              dec_sel_o,
    output logic              sdo_o
);
    localparam int TOP_BIT = FRAME_W - 1;

    logic [FRAME_W-1:0] sreg_q;
    logic               sdo_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sreg_q <= '0;
        end else if (sel_i && step_rise_i) begin
            sreg_q <= {sreg_q[FRAME_W-2:0], bit_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sdo_q <= 1'b0;
        end else if (sel_i && step_fall_i) begin
            sdo_q <= sreg_q[TOP_BIT];
        end
    end

    assign data_o    = sreg_q[CODE_W-1:0];
    assign dec_en_o  = sreg_q[TOP_BIT];
    assign dec_sel_o = sreg_q[CODE_W];
    assign sdo_o     = sdo_q;
endmodule

// File: rtl/load_fsm.sv
module load_fsm
    import dacfe_pkg::*;
#(
    parameter int CODE_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [CODE_W-1:0] data_i,
    input  logic              dec_en_i,
    input  logic              dec_sel_i,
    input  logic              rise_a_i,
    input  logic              rise_b_i,
    input  logic              clr_i,
    input  logic              mid_i,
    output ld_state_e         state_o,
    output logic [CODE_W-1:0] chan_a_o,
    output logic [CODE_W-1:0] chan_b_o
);
    localparam logic [CODE_W-1:0] ZERO_CODE = '0;
    localparam logic [CODE_W-1:0] MID_CODE  = {1'b1, {(CODE_W-1){1'b0}}};

    ld_state_e         st_q, st_d;
    dest_t             pend_q, pend_d;
    logic [CODE_W-1:0] pend_data_q;
    logic [CODE_W-1:0] chan_a_q, chan_b_q;
    logic [CODE_W-1:0] fill_code;
    logic              any_rise;

    assign any_rise  = rise_a_i | rise_b_i;
    assign fill_code = mid_i ? MID_CODE : ZERO_CODE;

    // destination of a pending load: address decode or strobe choice
    always_comb begin
        if (dec_en_i) begin
            pend_d.to_a = ~dec_sel_i;
            pend_d.to_b =  dec_sel_i;
        end else begin
            pend_d.to_a = rise_a_i;
            pend_d.to_b = rise_b_i;
        end
    end

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: begin
                if (clr_i)         st_d = ST_CLEAR;
                else if (any_rise) st_d = ST_COMMIT;
            end
            ST_COMMIT: st_d = clr_i ? ST_CLEAR : ST_IDLE;
            ST_CLEAR:  st_d = clr_i ? ST_CLEAR : ST_IDLE;
            default:   st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    // outputs: pending capture and channel registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_q      <= '0;
            pend_data_q <= '0;
            chan_a_q    <= '0;
            chan_b_q    <= '0;
        end else begin
            unique case (st_q)
                ST_IDLE: begin
                    if (!clr_i && any_rise) begin
                        pend_q      <= pend_d;
                        pend_data_q <= data_i;
                    end
                end
                ST_COMMIT: begin
                    if (!clr_i) begin
                        if (pend_q.to_a) chan_a_q <= pend_data_q;
                        if (pend_q.to_b) chan_b_q <= pend_data_q;
                    end
                end
                ST_CLEAR: begin
                    chan_a_q <= fill_code;
                    chan_b_q <= fill_code;
                end
                default: begin
                    chan_a_q <= chan_a_q;
                end
            endcase
        end
    end

    assign state_o  = st_q;
    assign chan_a_o = chan_a_q;
    assign chan_b_o = chan_b_q;
endmodule

// File: rtl/dac_serial_front.sv
module dac_serial_front
    import dacfe_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sclk_i,
    input  logic              sdi_i,
    input  logic              cs_n_i,
    input  logic              load_a_i,
    input  logic              load_b_i,
    input  logic              clear_i,
    input  logic              mid_i,
    output logic              sdo_o,
    output logic [CODE_W-1:0] chan_a_o,
    output logic [CODE_W-1:0] chan_b_o
);
    localparam int IX_SCLK = 0;
    localparam int IX_SDI  = 1;
    localparam int IX_CSN  = 2;
    localparam int IX_LDA  = 3;
    localparam int IX_LDB  = 4;
    localparam int IX_CLR  = 5;
    localparam int IX_MID  = 6;
    localparam int NSYNC   = 7;

    logic [NSYNC-1:0] raw_in, lvl;
    logic             sclk_prev_q, lda_prev_q, ldb_prev_q;
    logic             sclk_rise, sclk_fall, lda_rise, ldb_rise;
    logic             cs_active, clear_lvl, mid_lvl;
    logic [CODE_W-1:0] word_data;
    logic             word_dec_en, word_dec_sel;
    ld_state_e        ld_state;

    assign raw_in = {mid_i, clear_i, load_b_i, load_a_i, cs_n_i, sdi_i, sclk_i};

    bit_sync #(.N(NSYNC), .STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d_i   (raw_in),
        .q_o   (lvl)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            sclk_prev_q <= 1'b0;
            lda_prev_q  <= 1'b0;
            ldb_prev_q  <= 1'b0;
        end else begin
            sclk_prev_q <= lvl[IX_SCLK];
            lda_prev_q  <= lvl[IX_LDA];
            ldb_prev_q  <= lvl[IX_LDB];
        end
    end

    assign sclk_rise = lvl[IX_SCLK] & ~sclk_prev_q;
    assign sclk_fall = ~lvl[IX_SCLK] & sclk_prev_q;
    assign lda_rise  = lvl[IX_LDA] & ~lda_prev_q;
    assign ldb_rise  = lvl[IX_LDB] & ~ldb_prev_q;
    assign cs_active = ~lvl[IX_CSN];
    assign clear_lvl = lvl[IX_CLR];
    assign mid_lvl   = lvl[IX_MID];

    frame_shifter #(.FRAME_W(FRAME_W), .CODE_W(CODE_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .sel_i       (cs_active),
        .step_rise_i (sclk_rise),
        .step_fall_i (sclk_fall),
        .bit_i       (lvl[IX_SDI]),
        .data_o      (word_data),
        .dec_en_o    (word_dec_en),
        .dec_sel_o   (word_dec_sel),
        .sdo_o       (sdo_o)
    );

    load_fsm #(.CODE_W(CODE_W)) u_load (
        .clk       (clk),
        .rst_n     (rst_n),
        .data_i    (word_data),
        .dec_en_i  (word_dec_en),
        .dec_sel_i (word_dec_sel),
        .rise_a_i  (lda_rise),
        .rise_b_i  (ldb_rise),
        .clr_i     (clear_lvl),
        .mid_i     (mid_lvl),
        .state_o   (ld_state),
        .chan_a_o  (chan_a_o),
        .chan_b_o  (chan_b_o)
    );
endmodule

// File: rtl/dac_serial_front_chk.sv
module dac_serial_front_chk
    import dacfe_pkg::*;
(
    input logic              clk,
    input logic              rst_n,
    input ld_state_e         st,
    input logic              sel,
    input logic              sclk_fall,
    input logic [CODE_W-1:0] data,
    input logic              dec_en,
    input logic              dec_sel,
    input logic              sdo,
    input logic              clr,
    input logic              mid,
    input logic [CODE_W-1:0] chan_a,
    input logic [CODE_W-1:0] chan_b
);
    localparam logic [CODE_W-1:0] MID_CODE = {1'b1, {(CODE_W-1){1'b0}}};

    // R3
    shift_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sel |=> $stable({dec_en, dec_sel, data}));

    // R4
    sdo_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !sclk_fall |=> $stable(sdo));

    // R5
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |=> ($stable(chan_a) && $stable(chan_b)));

    // R7
    clear_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CLEAR && !mid) |=> (chan_a == '0 && chan_b == '0));

    // R7
    clear_mid_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CLEAR && mid) |=> (chan_a == MID_CODE && chan_b == MID_CODE));

    // R8
    clear_prio_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_COMMIT && clr) |=> ($stable(chan_a) && $stable(chan_b)));
endmodule

bind dac_serial_front dac_serial_front_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .st        (ld_state),
    .sel       (cs_active),
    .sclk_fall (sclk_fall),
    .data      (word_data),
    .dec_en    (word_dec_en),
    .dec_sel   (word_dec_sel),
    .sdo       (sdo_o),
    .clr       (clear_lvl),
    .mid       (mid_lvl),
    .chan_a    (chan_a_o),
    .chan_b    (chan_b_o)
);

// File: tb/tb_dac_serial_front.sv
module tb_dac_serial_front;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sclk = 1'b0, sdi = 1'b0, cs_n = 1'b1;
    logic        load_a = 1'b0, load_b = 1'b0, clear = 1'b0, mid = 1'b0;
    logic        sdo;
    logic [11:0] chan_a, chan_b;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    dac_serial_front dut (
        .clk(clk), .rst_n(rst_n), .sclk_i(sclk), .sdi_i(sdi), .cs_n_i(cs_n),
        .load_a_i(load_a), .load_b_i(load_b), .clear_i(clear), .mid_i(mid),
        .sdo_o(sdo), .chan_a_o(chan_a), .chan_b_o(chan_b)
    );

    // behavioural reference: two-sample pin delay, edge flags, pending load
    logic [6:0]  p1, p2;
    logic        m_sclk_prev, m_la_prev, m_lb_prev;
    logic [15:0] m_word;
    logic        m_sdo;
    logic [11:0] m_a, m_b, m_pdata;
    logic        m_pa, m_pb;
    int          m_mode;

    always @(posedge clk) begin
        if (!rst_n) begin
            p1 = '0; p2 = '0;
            m_sclk_prev = 0; m_la_prev = 0; m_lb_prev = 0;
            m_word = '0; m_sdo = 0; m_a = '0; m_b = '0;
            m_pdata = '0; m_pa = 0; m_pb = 0; m_mode = 0;
        end else begin
            logic s_r, s_f, a_r, b_r, clr_l, sel_l;
            logic [11:0] fill;
            s_r   = p2[0] & ~m_sclk_prev;
            s_f   = ~p2[0] & m_sclk_prev;
            a_r   = p2[3] & ~m_la_prev;
            b_r   = p2[4] & ~m_lb_prev;
            sel_l = ~p2[2];
            clr_l = p2[5];
            fill  = p2[6] ? 12'h800 : 12'h000;
            if (m_mode == 0) begin
                if (clr_l) m_mode = 2;
                else if (a_r || b_r) begin
                    if (m_word[15]) begin m_pa = ~m_word[12]; m_pb = m_word[12]; end
                    else begin m_pa = a_r; m_pb = b_r; end
                    m_pdata = m_word[11:0];
                    m_mode = 1;
                end
            end else if (m_mode == 1) begin
                if (!clr_l) begin
                    if (m_pa) m_a = m_pdata;
                    if (m_pb) m_b = m_pdata;
                end
                m_mode = clr_l ? 2 : 0;
            end else begin
                m_a = fill; m_b = fill;
                m_mode = clr_l ? 2 : 0;
            end
            if (sel_l && s_f) m_sdo = m_word[15];
            if (sel_l && s_r) m_word = {m_word[14:0], p2[1]};
            m_sclk_prev = p2[0]; m_la_prev = p2[3]; m_lb_prev = p2[4];
            p2 = p1;
            p1 = {mid, clear, load_b, load_a, cs_n, sdi, sclk};
        end
    end

    // R11: cycle-accurate comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) begin
            checks++;
            if (chan_a !== m_a || chan_b !== m_b || sdo !== m_sdo) begin
                failures++;
                $display("FAIL R11 model mismatch actual=%h/%h/%b expected=%h/%h/%b",
                         chan_a, chan_b, sdo, m_a, m_b, m_sdo);
            end
        end
    end

    task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic send_word(input logic [15:0] w, input logic [15:0] prev, input bit see_sdo);
        cs_n = 1'b0;
        tick(3);
        for (int i = 15; i >= 0; i--) begin
            sdi = w[i];
            tick(3);
            sclk = 1'b1;
            tick(4);
            sclk = 1'b0;
            tick(4);
            if (see_sdo) chk("R4 chained sdo", {15'd0, sdo}, {15'd0, (i > 0) ? prev[i-1] : w[15]});
        end
        tick(3);
        cs_n = 1'b1;
        tick(4);
    endtask

    task automatic pulse(input logic a, input logic b, input int len);
        load_a = a; load_b = b;
        tick(len);
        load_a = 1'b0; load_b = 1'b0;
        tick(6);
    endtask

    task automatic do_clear(input int len);
        clear = 1'b1;
        tick(len);
        clear = 1'b0;
        tick(6);
    endtask

    initial begin
        tick(5);
        rst_n = 1'b1;
        tick(3);
        // R1
        chk("R1 chan_a after reset", {4'd0, chan_a}, 16'h000);
        chk("R1 chan_b after reset", {4'd0, chan_b}, 16'h000);
        chk("R1 sdo after reset", {15'd0, sdo}, 16'h0);

        // R5 / R2: external strobe selection
        send_word(16'h0ABC, 16'h0, 1'b0);
        chk("R4 sdo holds bit15 after frame", {15'd0, sdo}, 16'h0);
        pulse(1, 0, 4);
        chk("R5 strobe A loads A", {4'd0, chan_a}, 16'h0ABC);
        chk("R5 strobe A leaves B", {4'd0, chan_b}, 16'h000);
        send_word(16'h0123, 16'h0ABC, 1'b1);
        pulse(0, 1, 4);
        chk("R5 strobe B loads B", {4'd0, chan_b}, 16'h0123);
        chk("R5 strobe B leaves A", {4'd0, chan_a}, 16'h0ABC);

        // R6 / R10 / R4: decoded load with the opposite strobe, chained output
        send_word(16'h9FFF, 16'h0123, 1'b1);
        pulse(1, 0, 4);
        chk("R6 decoded to B via strobe A", {4'd0, chan_b}, 16'h0FFF);
        chk("R10 full scale on A untouched", {4'd0, chan_a}, 16'h0ABC);
        send_word(16'h8555, 16'h9FFF, 1'b0);
        pulse(0, 1, 4);
        chk("R6 decoded to A via strobe B", {4'd0, chan_a}, 16'h0555);
        chk("R6 B unchanged", {4'd0, chan_b}, 16'h0FFF);

        // R3: clocking with select high
        sdi = 1'b0;
        for (int k = 0; k < 16; k++) begin
            sclk = 1'b1; tick(4); sclk = 1'b0; tick(4);
        end
        tick(4);
        chk("R3 sdo unchanged without select", {15'd0, sdo}, 16'h1);
        pulse(0, 1, 4);
        chk("R3 word kept: B still unchanged", {4'd0, chan_b}, 16'h0FFF);

        // R2: bits 14:13 ignored
        send_word(16'hE001, 16'h8555, 1'b0);
        pulse(0, 1, 4);
        chk("R2 address bits 14:13 ignored", {4'd0, chan_a}, 16'h0001);

        // R7: clear to zero then to midscale
        mid = 1'b0;
        do_clear(4);
        chk("R7 clear zero A", {4'd0, chan_a}, 16'h000);
        chk("R7 clear zero B", {4'd0, chan_b}, 16'h000);
        send_word(16'h0321, 16'hE001, 1'b0);
        pulse(1, 0, 4);
        chk("R5 load after clear", {4'd0, chan_a}, 16'h0321);
        mid = 1'b1;
        tick(4);
        do_clear(4);
        chk("R7 clear mid A", {4'd0, chan_a}, 16'h800);
        chk("R7 clear mid B", {4'd0, chan_b}, 16'h800);

        // R8: strobe together with clear, during clear, and held past clear
        send_word(16'h0456, 16'h0321, 1'b0);
        clear = 1'b1; load_a = 1'b1;
        tick(5);
        load_a = 1'b0;
        tick(3);
        clear = 1'b0;
        tick(6);
        chk("R8 strobe with clear ignored", {4'd0, chan_a}, 16'h800);
        clear = 1'b1;
        tick(3);
        load_b = 1'b1; tick(3); load_b = 1'b0; tick(3);
        clear = 1'b0;
        tick(6);
        chk("R8 strobe inside clear ignored", {4'd0, chan_b}, 16'h800);
        clear = 1'b1;
        tick(3);
        load_b = 1'b1;
        tick(3);
        clear = 1'b0;
        tick(8);
        chk("R8 strobe held past clear ignored", {4'd0, chan_b}, 16'h800);
        load_b = 1'b0;
        tick(6);

        // R9: one load per pulse
        send_word(16'h0777, 16'h0456, 1'b0);
        load_a = 1'b1;
        tick(6);
        chk("R9 load on rising edge", {4'd0, chan_a}, 16'h0777);
        send_word(16'h0AAA, 16'h0777, 1'b1);
        chk("R9 held strobe no reload", {4'd0, chan_a}, 16'h0777);
        load_a = 1'b0;
        tick(6);
        chk("R9 no load on falling edge", {4'd0, chan_a}, 16'h0777);
        pulse(1, 0, 3);
        chk("R9 next pulse loads", {4'd0, chan_a}, 16'h0AAA);

        // R5: both strobes together, external mode
        send_word(16'h0F0F, 16'h0AAA, 1'b0);
        pulse(1, 1, 4);
        chk("R5 both strobes A", {4'd0, chan_a}, 16'h0F0F);
        chk("R5 both strobes B", {4'd0, chan_b}, 16'h0F0F);

        tick(4);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            failures++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end
endmodule